// File: doc/BRIEF.md
# Open-Page Bank Access Latency Estimator

This block predicts how long a memory request will take to reach its first data beat when it targets one bank of a DRAM device run under an open-page policy. A scheduler presents a request together with that bank's bookkeeping: the arrival time, whether a row is open and which one, the time the bank becomes free, and the earliest time the bank may receive an activate. The earliest-activate time is set by a separate activation-window limiter. The block returns three things: the total access latency, the part of that latency spent inside the bank, and a flag that marks a row hit.

There are three cases. A row hit only waits for the bank and then pays the column latency. A request to a closed bank must activate a row. A request that finds a different row open must precharge before it can activate. In the last two cases the planned activate may land before the limiter allows it. The estimate then grows by the shortfall, so a request can stall even when the bank itself is idle.

Each estimate starts with a one-cycle `in_valid` pulse. The result appears with `out_valid` after a fixed, parameterised number of cycles (1 or 2). A new estimate can start on every cycle.

Top module: `lat_est_bank_open_page`

## Requirements
- R1: `out_valid` is high exactly LATENCY cycles after each cycle in which `in_valid` was high, and never otherwise. While `out_valid` is low, `acc_lat`, `bank_lat` and `row_hit` hold their last values.
- R2: A request is a row hit when `row_open`=1 and `open_row`=`req_row`. A row hit gives `row_hit`=1, `acc_lat` = free wait + `t_cl` and `bank_lat` = `t_cl`.
- R3: `row_hit` is 0 in the result of every estimate that is not a row hit, even when the estimate before it was a hit.
- R4: The free wait is `free_at` − `arrival` when `free_at` > `arrival`, and 0 otherwise (equal times give 0).
- R5: Row miss (`row_open`=1, rows differ). Let the projected activate time be `arrival` + free wait + `t_rp`. The stall is `act_allowed` − projected when that is positive, else 0. Then `acc_lat` = free wait + stall + `t_rp`+`t_rcd`+`t_cl`, and `bank_lat` = `t_rp`+`t_rcd`+`t_cl`.
- R6: Closed bank (`row_open`=0). Let the projected activate time be `arrival` + free wait, with the stall taken against `act_allowed` in the same way. Then `acc_lat` = free wait + stall + `t_rcd`+`t_cl`, and `bank_lat` = `t_rcd`+`t_cl`.
- R7: When `act_allowed` is at or before the projected activate time, no stall is added. A row hit never adds a stall, whatever the value of `act_allowed`.
- R8: While `rst_n` is low, `out_valid`, `acc_lat`, `bank_lat` and `row_hit` are all 0.
- R9: A latency that does not fit in LAT_W bits is reported as all ones (saturation).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Starts an estimate with this cycle's inputs |
| arrival | input | TIME_W | Request arrival time |
| row_open | input | 1 | A row is open in the bank |
| open_row | input | ROW_W | Currently open row |
| req_row | input | ROW_W | Row the request targets |
| free_at | input | TIME_W | Time the bank becomes free |
| act_allowed | input | TIME_W | Earliest time an activate may issue |
| t_rp | input | TPAR_W | Precharge time |
| t_rcd | input | TPAR_W | Activate-to-column time |
| t_cl | input | TPAR_W | Column-to-data latency |
| out_valid | output | 1 | Result is valid |
| acc_lat | output | LAT_W | Total access latency |
| bank_lat | output | LAT_W | Latency spent inside the bank |
| row_hit | output | 1 | Request was a row hit |

## Verification
With the default LATENCY of 2, all three results for a request sampled at a rising edge appear together two edges later, and they stay put until the next result. The driver stamps each expected item with the cycle in which it is due. The monitor samples on the falling edge, pops the oldest item whenever `out_valid` is high, and compares both the values and the due cycle, so an early or late result fails even when its values are right. Idle stretches check that no extra result appears and that the outputs hold.

// File: rtl/lat_est_pkg.sv
package lat_est_pkg;

   typedef enum logic [1:0] {
      ACC_HIT    = 2'd0,
      ACC_MISS   = 2'd1,
      ACC_CLOSED = 2'd2
   } acc_kind_e;

endpackage

// File: rtl/lat_est_classify.sv
module lat_est_classify
   import lat_est_pkg::*;
#(
   parameter int TIME_W = 32,
   parameter int ROW_W  = 14,
   parameter int TPAR_W = 8
) (
   input  logic                row_open,
   input  logic [ROW_W-1:0]    open_row,
   input  logic [ROW_W-1:0]    req_row,
   input  logic [TIME_W-1:0]   arrival,
   input  logic [TIME_W-1:0]   free_at,
   input  logic [TPAR_W-1:0]   t_rp,
   output acc_kind_e           kind,
   output logic [TIME_W-1:0]   wait_free,
   output logic [TIME_W+1:0]   proj_act
);
   localparam int EXT_W = TIME_W + 2;

   logic               late_free;
   logic [EXT_W-1:0]   ready_ext;
   logic [EXT_W-1:0]   pre_ext;

   always_comb begin
      if (!row_open)                kind = ACC_CLOSED;
      else if (open_row == req_row) kind = ACC_HIT;
      else                          kind = ACC_MISS;
   end

   assign late_free = free_at > arrival;
   assign wait_free = late_free ? (free_at - arrival) : '0;
   assign ready_ext = {2'b00, (late_free ? free_at : arrival)};
   assign pre_ext   = (kind == ACC_MISS) ? EXT_W'(t_rp) : '0;
   assign proj_act  = ready_ext + pre_ext;

endmodule

// File: rtl/lat_est_act_stall.sv
module lat_est_act_stall #(
   parameter int TIME_W = 32
) (
   input  logic [TIME_W+1:0] proj_act,
   input  logic [TIME_W-1:0] act_allowed,
   output logic [TIME_W+1:0] stall
);
   localparam int EXT_W = TIME_W + 2;

   logic [EXT_W-1:0] allowed_ext;

   assign allowed_ext = {2'b00, act_allowed};
   assign stall       = (allowed_ext > proj_act) ? (allowed_ext - proj_act) : '0;

endmodule

// File: rtl/lat_est_sum.sv
module lat_est_sum
   import lat_est_pkg::*;
#(
   parameter int TIME_W = 32,
   parameter int TPAR_W = 8,
   parameter int LAT_W  = 32
) (
   input  acc_kind_e          kind,
   input  logic [TIME_W-1:0]  wait_free,
   input  logic [TIME_W+1:0]  stall,
   input  logic [TPAR_W-1:0]  t_rp,
   input  logic [TPAR_W-1:0]  t_rcd,
   input  logic [TPAR_W-1:0]  t_cl,
   output logic [LAT_W-1:0]   acc_lat,
   output logic [LAT_W-1:0]   bank_lat,
   output logic               row_hit
);
   localparam int SUM_W = TIME_W + 4;

   logic [SUM_W-1:0] fixed;
   logic [SUM_W-1:0] stall_used;
   logic [SUM_W-1:0] acc_raw;

   function automatic logic [LAT_W-1:0] sat_lat(input logic [SUM_W-1:0] v);
      if (|v[SUM_W-1:LAT_W]) return '1;
      return v[LAT_W-1:0];
   endfunction

   always_comb begin
      unique case (kind)
         ACC_HIT:  fixed = SUM_W'(t_cl);
         ACC_MISS: fixed = SUM_W'(t_rp) + SUM_W'(t_rcd) + SUM_W'(t_cl);
         default:  fixed = SUM_W'(t_rcd) + SUM_W'(t_cl);
      endcase
   end

   assign stall_used = (kind == ACC_HIT) ? '0 : SUM_W'(stall);
   assign acc_raw    = SUM_W'(wait_free) + stall_used + fixed;
   assign acc_lat    = sat_lat(acc_raw);
   assign bank_lat   = sat_lat(fixed);
   assign row_hit    = (kind == ACC_HIT);

endmodule

// File: rtl/lat_est_bank_open_page.sv
module lat_est_bank_open_page
   import lat_est_pkg::*;
#(
   parameter int TIME_W  = 32,
   parameter int ROW_W   = 14,
   parameter int TPAR_W  = 8,
   parameter int LAT_W   = 32,
   parameter int LATENCY = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [TIME_W-1:0]  arrival,
   input  logic               row_open,
   input  logic [ROW_W-1:0]   open_row,
   input  logic [ROW_W-1:0]   req_row,
   input  logic [TIME_W-1:0]  free_at,
   input  logic [TIME_W-1:0]  act_allowed,
   input  logic [TPAR_W-1:0]  t_rp,
   input  logic [TPAR_W-1:0]  t_rcd,
   input  logic [TPAR_W-1:0]  t_cl,
   output logic               out_valid,
   output logic [LAT_W-1:0]   acc_lat,
   output logic [LAT_W-1:0]   bank_lat,
   output logic               row_hit
);
   localparam int EXT_W = TIME_W + 2;

   if (LATENCY < 1 || LATENCY > 2) begin : g_bad_latency
      $error("LATENCY must be 1 or 2");
   end
   if (LAT_W < TPAR_W + 2 || LAT_W > TIME_W + 3) begin : g_bad_lat_w
      $error("LAT_W must lie in TPAR_W+2 .. TIME_W+3");
   end
   if (TIME_W < 8 || ROW_W < 1 || TPAR_W < 2) begin : g_bad_widths
      $error("TIME_W, ROW_W or TPAR_W too small");
   end

   // stage 1: classify and project the activate time
   acc_kind_e          s1_kind;
   logic [TIME_W-1:0]  s1_wait;
   logic [EXT_W-1:0]   s1_proj;

   lat_est_classify #(
      .TIME_W (TIME_W),
      .ROW_W  (ROW_W),
      .TPAR_W (TPAR_W)
   ) u_classify (
      .row_open  (row_open),
      .open_row  (open_row),
      .req_row   (req_row),
      .arrival   (arrival),
      .free_at   (free_at),
      .t_rp      (t_rp),
      .kind      (s1_kind),
      .wait_free (s1_wait),
      .proj_act  (s1_proj)
   );

   // stage boundary, chosen by LATENCY
   logic               s2_valid;
   acc_kind_e          s2_kind;
   logic [TIME_W-1:0]  s2_wait;
   logic [EXT_W-1:0]   s2_proj;
   logic [TIME_W-1:0]  s2_allowed;
   logic [TPAR_W-1:0]  s2_rp;
   logic [TPAR_W-1:0]  s2_rcd;
   logic [TPAR_W-1:0]  s2_cl;

   if (LATENCY == 2) begin : g_mid_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s2_valid   <= 1'b0;
            s2_kind    <= ACC_CLOSED;
            s2_wait    <= '0;
            s2_proj    <= '0;
            s2_allowed <= '0;
            s2_rp      <= '0;
            s2_rcd     <= '0;
            s2_cl      <= '0;
         end else begin
            s2_valid <= in_valid;
            if (in_valid) begin
               s2_kind    <= s1_kind;
               s2_wait    <= s1_wait;
               s2_proj    <= s1_proj;
               s2_allowed <= act_allowed;
               s2_rp      <= t_rp;
               s2_rcd     <= t_rcd;
               s2_cl      <= t_cl;
            end
         end
      end
   end else begin : g_mid_wire
      assign s2_valid   = in_valid;
      assign s2_kind    = s1_kind;
      assign s2_wait    = s1_wait;
      assign s2_proj    = s1_proj;
      assign s2_allowed = act_allowed;
      assign s2_rp      = t_rp;
      assign s2_rcd     = t_rcd;
      assign s2_cl      = t_cl;
   end

   // stage 2: activation-window stall and totals
   logic [EXT_W-1:0]  s2_stall;
   logic [LAT_W-1:0]  s2_acc;
   logic [LAT_W-1:0]  s2_bank;
   logic              s2_hit;

   lat_est_act_stall #(
      .TIME_W (TIME_W)
   ) u_stall (
      .proj_act    (s2_proj),
      .act_allowed (s2_allowed),
      .stall       (s2_stall)
   );

   lat_est_sum #(
      .TIME_W (TIME_W),
      .TPAR_W (TPAR_W),
      .LAT_W  (LAT_W)
   ) u_sum (
      .kind      (s2_kind),
      .wait_free (s2_wait),
      .stall     (s2_stall),
      .t_rp      (s2_rp),
      .t_rcd     (s2_rcd),
      .t_cl      (s2_cl),
      .acc_lat   (s2_acc),
      .bank_lat  (s2_bank),
      .row_hit   (s2_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         acc_lat   <= '0;
         bank_lat  <= '0;
         row_hit   <= 1'b0;
      end else begin
         out_valid <= s2_valid;
         if (s2_valid) begin
            acc_lat  <= s2_acc;
            bank_lat <= s2_bank;
            row_hit  <= s2_hit;
         end
      end
   end

endmodule

// File: rtl/lat_est_chk.sv
module lat_est_chk #(
   parameter int TIME_W  = 32,
   parameter int ROW_W   = 14,
   parameter int TPAR_W  = 8,
   parameter int LAT_W   = 32,
   parameter int LATENCY = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic [TIME_W-1:0]  arrival,
   input logic               row_open,
   input logic [ROW_W-1:0]   open_row,
   input logic [ROW_W-1:0]   req_row,
   input logic [TIME_W-1:0]  free_at,
   input logic [TIME_W-1:0]  act_allowed,
   input logic [TPAR_W-1:0]  t_rp,
   input logic [TPAR_W-1:0]  t_rcd,
   input logic [TPAR_W-1:0]  t_cl,
   input logic               out_valid,
   input logic [LAT_W-1:0]   acc_lat,
   input logic [LAT_W-1:0]   bank_lat,
   input logic               row_hit
);
   logic [1:0]         since_rst;
   logic               warm;
   logic               hit_in;
   logic [TPAR_W+1:0]  miss_sum;
   logic [TPAR_W+1:0]  closed_sum;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   assign warm       = (32'(since_rst) >= LATENCY);
   assign hit_in     = row_open && (open_row == req_row);
   assign miss_sum   = {2'b00, t_rp} + {2'b00, t_rcd} + {2'b00, t_cl};
   assign closed_sum = {2'b00, t_rcd} + {2'b00, t_cl};

   // R1: result appears exactly LATENCY cycles after a request
   a_r1_valid_timing: assert property (@(posedge clk) disable iff (!rst_n)
      warm |-> (out_valid == $past(in_valid, LATENCY)));

   // R1: results hold while no result is presented
   a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst != 2'd0 && !out_valid) |-> ($stable(acc_lat) && $stable(bank_lat) && $stable(row_hit)));

   // R2: hit reports only the column latency inside the bank
   a_r2_hit_bank: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && out_valid && row_hit) |-> (bank_lat == LAT_W'($past(t_cl, LATENCY))));

   // R3: hit flag only for a matching open row
   a_r3_hit_only_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && out_valid) |-> (row_hit == $past(hit_in, LATENCY)));

   // R5: row-miss bank latency
   a_r5_miss_bank: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && out_valid && !row_hit && $past(row_open, LATENCY))
      |-> (bank_lat == LAT_W'($past(miss_sum, LATENCY))));

   // R6: closed-bank bank latency
   a_r6_closed_bank: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && out_valid && !$past(row_open, LATENCY))
      |-> (bank_lat == LAT_W'($past(closed_sum, LATENCY))));

   // R5, R6: the total never falls below the in-bank part
   a_r5_acc_ge_bank: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (acc_lat >= bank_lat));

endmodule

bind lat_est_bank_open_page lat_est_chk #(
   .TIME_W  (TIME_W),
   .ROW_W   (ROW_W),
   .TPAR_W  (TPAR_W),
   .LAT_W   (LAT_W),
   .LATENCY (LATENCY)
) u_chk (.*);

// File: tb/tb_lat_est_bank_open_page.sv
`timescale 1ns/1ps
module tb_lat_est_bank_open_page;
   localparam int TIME_W  = 32;
   localparam int ROW_W   = 14;
   localparam int TPAR_W  = 8;
   localparam int LAT_W   = 32;
   localparam int LATENCY = 2;
   localparam longint LMAX = (64'd1 << LAT_W) - 1;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               in_valid = 1'b0;
   logic [TIME_W-1:0]  arrival = '0;
   logic               row_open = 1'b0;
   logic [ROW_W-1:0]   open_row = '0;
   logic [ROW_W-1:0]   req_row = '0;
   logic [TIME_W-1:0]  free_at = '0;
   logic [TIME_W-1:0]  act_allowed = '0;
   logic [TPAR_W-1:0]  t_rp = '0;
   logic [TPAR_W-1:0]  t_rcd = '0;
   logic [TPAR_W-1:0]  t_cl = '0;
   logic               out_valid;
   logic [LAT_W-1:0]   acc_lat;
   logic [LAT_W-1:0]   bank_lat;
   logic               row_hit;

   always #2.5 clk = ~clk;

   lat_est_bank_open_page #(
      .TIME_W(TIME_W), .ROW_W(ROW_W), .TPAR_W(TPAR_W), .LAT_W(LAT_W), .LATENCY(LATENCY)
   ) dut (.*);

   typedef struct {
      longint acc;
      longint bank;
      bit     hit;
      int     due;
      string  tag;
   } exp_t;

   exp_t   sb[$];
   int     cyc = 0;
   int     checks = 0;
   int     fails = 0;
   bit     done = 1'b0;
   longint last_acc = 0;
   longint last_bank = 0;
   bit     last_hit = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(string tag, longint act, longint expv, string what);
      checks++;
      if (act != expv) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   function automatic exp_t model(longint arr, bit ro, int orow, int rrow,
                                  longint fr, longint aa, int rp, int rcd, int cl);
      exp_t   e;
      longint wt, proj, st;
      wt = (fr > arr) ? fr - arr : 0;                 // R4
      if (ro && orow == rrow) begin                   // R2
         e.acc = wt + cl; e.bank = cl; e.hit = 1'b1;
      end else begin
         proj = arr + wt + (ro ? rp : 0);             // R5 / R6
         st   = (aa > proj) ? aa - proj : 0;          // R7
         e.bank = ro ? (rp + rcd + cl) : (rcd + cl);
         e.acc  = wt + st + e.bank;
         e.hit  = 1'b0;                               // R3
      end
      if (e.acc > LMAX) e.acc = LMAX;                 // R9
      return e;
   endfunction

   // driver: called at a falling edge, returns one falling edge later
   task automatic send(string tag, longint arr, bit ro, int orow, int rrow,
                       longint fr, longint aa, int rp, int rcd, int cl);
      exp_t e;
      e = model(arr, ro, orow, rrow, fr, aa, rp, rcd, cl);
      e.due = cyc + LATENCY;
      e.tag = tag;
      sb.push_back(e);
      in_valid    = 1'b1;
      arrival     = arr[TIME_W-1:0];
      row_open    = ro;
      open_row    = orow[ROW_W-1:0];
      req_row     = rrow[ROW_W-1:0];
      free_at     = fr[TIME_W-1:0];
      act_allowed = aa[TIME_W-1:0];
      t_rp        = rp[TPAR_W-1:0];
      t_rcd       = rcd[TPAR_W-1:0];
      t_cl        = cl[TPAR_W-1:0];
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         // junk on the data inputs must not produce results (R1)
         arrival = arrival + 32'd7;
         row_open = ~row_open;
         @(negedge clk);
      end
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n && !done && out_valid) begin
         if (sb.size() == 0) begin
            checks++; fails++;
            $display("FAIL R1 unexpected out_valid: actual 1 expected 0");
         end else begin
            exp_t e;
            e = sb.pop_front();
            check("R1", longint'(cyc), longint'(e.due), {e.tag, " due cycle"});
            check(e.tag, longint'(acc_lat), e.acc, "acc_lat");
            check(e.tag, longint'(bank_lat), e.bank, "bank_lat");
            check(e.tag == "R2" ? "R2" : "R3", longint'(row_hit), longint'(e.hit), "row_hit");
            last_acc = e.acc; last_bank = e.bank; last_hit = e.hit;
         end
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired: actual running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R8: reset state
      check("R8", longint'(out_valid), 0, "out_valid in reset");
      check("R8", longint'(acc_lat), 0, "acc_lat in reset");
      check("R8", longint'(bank_lat), 0, "bank_lat in reset");
      check("R8", longint'(row_hit), 0, "row_hit in reset");
      rst_n = 1'b1;
      @(negedge clk);

      // hits, bank free earlier and later (R2, R4); stall ignored on hit (R7)
      send("R2", 100, 1, 5, 5, 90, 500, 5, 6, 4);
      send("R2", 100, 1, 5, 5, 130, 0, 5, 6, 4);
      // miss without stall, with stall, and at the boundary (R5, R7)
      send("R3", 200, 1, 3, 9, 210, 0, 5, 6, 4);
      send("R5", 200, 1, 3, 9, 210, 240, 5, 6, 4);
      send("R7", 200, 1, 3, 9, 210, 215, 5, 6, 4);
      send("R7", 200, 1, 3, 9, 210, 216, 5, 6, 4);
      // closed bank (R6)
      send("R6", 300, 0, 0, 1, 0, 320, 5, 6, 4);
      send("R6", 300, 0, 0, 1, 0, 100, 5, 6, 4);
      send("R6", 300, 0, 0, 1, 310, 305, 9, 3, 2);
      // free time equal to arrival gives no wait (R4)
      send("R4", 400, 1, 1, 2, 400, 0, 7, 7, 7);
      send("R4", 400, 0, 1, 1, 400, 400, 7, 7, 7);
      idle(4);
      // hold after the last result (R1)
      check("R1", longint'(out_valid), 0, "out_valid idle");
      check("R1", longint'(acc_lat), last_acc, "acc_lat held");
      check("R1", longint'(bank_lat), last_bank, "bank_lat held");
      check("R1", longint'(row_hit), longint'(last_hit), "row_hit held");

      // hit followed by miss and closed, with gaps (R3)
      send("R2", 1000, 1, 8, 8, 0, 0, 10, 11, 12);
      idle(1);
      send("R3", 1000, 1, 8, 7, 0, 1030, 10, 11, 12);
      send("R2", 50, 1, 0, 0, 60, 0, 1, 1, 255);
      send("R3", 50, 0, 0, 0, 60, 0, 1, 1, 255);
      // large values and saturation (R9)
      send("R9", 0, 1, 1, 2, 64'hFFFF_FFF0, 64'hFFFF_FFFF, 5, 6, 4);
      send("R9", 10, 0, 0, 0, 64'hFFFF_FFF0, 0, 255, 255, 255);
      send("R6", 0, 0, 0, 0, 64'h8000_0000, 64'h8000_0100, 3, 3, 3);
      idle(6);
      check("R1", longint'(sb.size()), 0, "pending results after drain");
      done = 1'b1;
      summary();
      $finish;
   end

endmodule